// File: doc/BRIEF.md
# Handshaked User Register File

This block sits behind a host bridge that presents a 4-bit register address, a read/write flag, a start strobe and an 8-bit write data bus. The block answers every transaction by raising an end signal (`done`) after a fixed, parameter-chosen number of wait cycles. The bridge holds the host until `done` rises. Read data is guaranteed valid while `done` is high.

Of the sixteen addresses, the lower fourteen are plain 8-bit storage registers. The second-highest address stores nothing. A write to it fires a one-cycle control pulse for neighbouring logic. The highest address is a status register holding a single pending-interrupt flag. A rising edge on an external event input sets that flag and drives the active-low interrupt request. The host services the request by writing a 1 to bit 0 of the status register.

Top module: `hs_regfile`

## Requirements
- R1: After reset, all storage registers read 0, `done` and `ctrl_pulse` are low and `irq_n` is high.
- R2: In the first cycle of a transaction (`start` high while the block is idle) with `rd_not_wr` = 0, `wr_data` is stored at `reg_addr` when that address is 0..13. `rd_not_wr` = 1 means read.
- R3: On a read, `rd_data` carries the register selected by `reg_addr` in every cycle that `done` is high.
- R4: `done` rises exactly LATENCY cycles after the first `start` cycle (LATENCY in 0..7). With LATENCY = 0 it is high in that first cycle.
- R5: Once high, `done` stays high as long as `start` stays high, and it is low in the cycle in which `start` is low.
- R6: A write to address 14 produces `ctrl_pulse` high for exactly the one cycle after the first `start` cycle. It stores nothing, and address 14 reads 0. Reads and writes to any other address produce no pulse.
- R7: A rising edge of `event_in` makes the interrupt pending, and `irq_n` is low from the next cycle on.
- R8: A read of address 15 returns the pending flag in bit 0 and zeros in bits 7..1.
- R9: A write to address 15 with bit 0 = 1 clears the pending flag and returns `irq_n` high on the next cycle. A write with bit 0 = 0 leaves it pending. A new event edge in the same cycle wins over the clear.
- R10: If `start` falls before `done` has risen, the transaction is abandoned. `done` does not rise, and the next transaction behaves normally.
- R11: Reads never change stored register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address from the bridge |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| start | input | 1 | Transaction start, held until `done` is seen |
| wr_data | input | 8 | Write data |
| event_in | input | 1 | External event; a rising edge raises an interrupt |
| done | output | 1 | Transaction end, active high |
| rd_data | output | 8 | Read data, valid while `done` is high |
| irq_n | output | 1 | Interrupt request, active low |
| ctrl_pulse | output | 1 | One-cycle strobe from a write to address 14 |

## Verification
The timing of each result is fixed, and the checks sample at those points.

- **Writes:** a write lands on the clock edge that closes the first `start` cycle.
- **Control pulse:** `ctrl_pulse` is seen one cycle after the first `start` cycle.
- **End signal:** `done` is seen LATENCY cycles after the first `start` cycle, or in the first cycle for a zero-latency build.
- **Interrupt:** `irq_n` changes one cycle after an event edge or a clearing write.

The bench drives inputs on the falling edge and samples shortly after it. It counts falling edges from the start of a transaction, so each check lands in exactly the cycle its requirement names. Two instances, with latency 3 and latency 0, receive the same stimulus. This lets both the delayed and the same-cycle end be checked on the same sweep.

// File: rtl/hs_regfile_pkg.sv
package hs_regfile_pkg;
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_WAIT = 2'd1,
      HS_HOLD = 2'd2
   } hs_state_t;

   localparam int HS_MAX_LATENCY = 7;
endpackage

// File: rtl/hs_handshake.sv
module hs_handshake
   import hs_regfile_pkg::*;
#(
   parameter int LATENCY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic done
);
   localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
   localparam int LOAD  = (LATENCY >= 2) ? LATENCY - 2 : 0;
   localparam logic [CNT_W-1:0] LOAD_V = LOAD[CNT_W-1:0];

   hs_state_t        state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= HS_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            HS_IDLE: begin
               if (start) begin
                  if (LATENCY <= 1) begin
                     state <= HS_HOLD;
                  end else begin
                     state <= HS_WAIT;
                     cnt   <= LOAD_V;
                  end
               end
            end
            HS_WAIT: begin
               if (!start)
                  state <= HS_IDLE;
               else if (cnt == '0)
                  state <= HS_HOLD;
               else
                  cnt <= cnt - 1'b1;
            end
            HS_HOLD: begin
               if (!start)
                  state <= HS_IDLE;
            end
            default: state <= HS_IDLE;
         endcase
      end
   end

   assign accept = start && (state == HS_IDLE);

   generate
      if (LATENCY == 0) begin : g_zero_wait
         assign done = start && ((state == HS_HOLD) || (state == HS_IDLE));
      end else begin : g_counted_wait
         assign done = start && (state == HS_HOLD);
      end
   endgenerate
endmodule

// File: rtl/hs_storage.sv
module hs_storage #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int N_REG  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [N_REG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_REG; i++)
            mem[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < N_REG; i++)
            if (addr == ADDR_W'(i))
               mem[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_REG; i++)
         if (addr == ADDR_W'(i))
            rdata = mem[i];
   end
endmodule

// File: rtl/hs_irq.sv
module hs_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic event_in,
   input  logic clear,
   output logic pending
);
   logic ev_q;
   logic ev_rise;

   assign ev_rise = event_in && !ev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_q    <= 1'b0;
         pending <= 1'b0;
      end else begin
         ev_q <= event_in;
         if (ev_rise)
            pending <= 1'b1;
         else if (clear)
            pending <= 1'b0;
      end
   end
endmodule

// File: rtl/hs_regfile.sv
module hs_regfile
   import hs_regfile_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4,
   parameter int LATENCY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              rd_not_wr,
   input  logic              start,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              event_in,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_n,
   output logic              ctrl_pulse
);
   localparam int N_ADDR = 1 << ADDR_W;
   localparam int N_REG  = N_ADDR - 2;
   localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(N_ADDR - 1);
   localparam logic [ADDR_W-1:0] STROBE_ADDR = ADDR_W'(N_ADDR - 2);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs_regfile: DATA_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("hs_regfile: ADDR_W must be at least 2");
      end
      if (LATENCY < 0 || LATENCY > HS_MAX_LATENCY) begin : g_bad_lat
         $error("hs_regfile: LATENCY out of range 0..7");
      end
   endgenerate

   logic              accept;
   logic              wr_acc;
   logic              store_wr;
   logic              irq_clear;
   logic              pending;
   logic              pulse_q;
   logic [DATA_W-1:0] store_rdata;

   hs_handshake #(.LATENCY(LATENCY)) u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .done   (done)
   );

   assign wr_acc    = accept && !rd_not_wr;
   assign store_wr  = wr_acc && (reg_addr < STROBE_ADDR);
   assign irq_clear = wr_acc && (reg_addr == STATUS_ADDR) && wr_data[0];

   hs_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_REG(N_REG)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (store_wr),
      .addr  (reg_addr),
      .wdata (wr_data),
      .rdata (store_rdata)
   );

   hs_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_in (event_in),
      .clear    (irq_clear),
      .pending  (pending)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         pulse_q <= 1'b0;
      else
         pulse_q <= wr_acc && (reg_addr == STROBE_ADDR);
   end

   always_comb begin
      if (reg_addr == STATUS_ADDR)
         rd_data = {{(DATA_W-1){1'b0}}, pending};
      else
         rd_data = store_rdata;
   end

   assign irq_n      = !pending;
   assign ctrl_pulse = pulse_q;
endmodule

// File: rtl/hs_regfile_chk.sv
module hs_regfile_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              rd_not_wr,
   input logic              start,
   input logic [DATA_W-1:0] wr_data,
   input logic              event_in,
   input logic              done,
   input logic              irq_n,
   input logic              ctrl_pulse
);
   localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'((1 << ADDR_W) - 1);
   localparam logic [ADDR_W-1:0] STROBE_ADDR = ADDR_W'((1 << ADDR_W) - 2);

   p_done_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> start);

   p_done_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (done || !start));

   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_pulse |=> !ctrl_pulse);

   p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_pulse |-> $past(start && !rd_not_wr && (reg_addr == STROBE_ADDR)));

   p_event_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(event_in) |=> !irq_n);

   p_release_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(start && !rd_not_wr && (reg_addr == STATUS_ADDR) && wr_data[0]));
endmodule

bind hs_regfile hs_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .rd_not_wr  (rd_not_wr),
   .start      (start),
   .wr_data    (wr_data),
   .event_in   (event_in),
   .done       (done),
   .irq_n      (irq_n),
   .ctrl_pulse (ctrl_pulse)
);

// File: tb/hs_regfile_tb.sv
`timescale 1ns/1ps
module hs_regfile_tb;
   localparam int LAT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       rd_not_wr = 1'b0;
   logic       start = 1'b0;
   logic [7:0] wr_data = '0;
   logic       event_in = 1'b0;
   logic       done, done0;
   logic [7:0] rd_data, rd_data0;
   logic       irq_n, irq_n0;
   logic       ctrl_pulse, ctrl_pulse0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hs_regfile #(.DATA_W(8), .ADDR_W(4), .LATENCY(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_not_wr(rd_not_wr),
      .start(start), .wr_data(wr_data), .event_in(event_in), .done(done),
      .rd_data(rd_data), .irq_n(irq_n), .ctrl_pulse(ctrl_pulse));

   hs_regfile #(.DATA_W(8), .ADDR_W(4), .LATENCY(0)) u_dut_l0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_not_wr(rd_not_wr),
      .start(start), .wr_data(wr_data), .event_in(event_in), .done(done0),
      .rd_data(rd_data0), .irq_n(irq_n0), .ctrl_pulse(ctrl_pulse0));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int p);
      return 8'((a * 37 + p * 11 + 5) & 255);
   endfunction

   task automatic txn(input logic rd, input logic [3:0] a, input logic [7:0] d,
                      output logic [7:0] got);
      int cyc;
      int pulses;
      @(negedge clk);
      reg_addr = a; rd_not_wr = rd; wr_data = d; start = 1'b1;
      cyc = 0; pulses = 0;
      #1;
      check("R4 zero-latency done in first cycle", int'(done0), 1);
      if (rd) check("R3 zero-latency read data", int'(rd_data0), int'(rd_data));
      while (done !== 1'b1 && cyc < 20) begin
         @(negedge clk); #1;
         cyc++;
         if (ctrl_pulse) pulses++;
      end
      check("R4 done latency", cyc, LAT);
      got = rd_data;
      @(negedge clk); #1;
      if (ctrl_pulse) pulses++;
      check("R5 done held while start high", int'(done), 1);
      start = 1'b0;
      #1;
      check("R5 done low with start low", int'(done), 0);
      check("R5 zero-latency done low with start low", int'(done0), 0);
      @(negedge clk); #1;
      if (ctrl_pulse) pulses++;
      check("R6 control pulse count", pulses, (!rd && a == 4'd14) ? 1 : 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] got;
      repeat (3) @(negedge clk);
      #1;
      check("R1 done after reset", int'(done), 0);
      check("R1 irq_n after reset", int'(irq_n), 1);
      check("R1 pulse after reset", int'(ctrl_pulse), 0);
      rst_n = 1'b1;
      for (int a = 0; a < 14; a++) begin
         txn(1'b1, 4'(a), 8'hff, got);
         check("R1 register reads zero after reset", int'(got), 0);
      end

      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < 15; a++)
            txn(1'b0, 4'(a), pat(a, p), got);
         for (int a = 0; a < 15; a++) begin
            txn(1'b1, 4'(a), 8'h00, got);
            if (a == 14) check("R6 strobe address reads zero", int'(got), 0);
            else check("R2 R3 stored value read back", int'(got), int'(pat(a, p)));
         end
         for (int a = 0; a < 14; a++) begin
            txn(1'b1, 4'(a), 8'h00, got);
            check("R11 read leaves contents unchanged", int'(got), int'(pat(a, p)));
         end
      end

      txn(1'b1, 4'd15, 8'h00, got);
      check("R8 status reads idle", int'(got), 0);
      @(negedge clk); event_in = 1'b1;
      @(negedge clk); #1;
      check("R7 irq_n low after event edge", int'(irq_n), 0);
      @(negedge clk); event_in = 1'b0;
      txn(1'b1, 4'd15, 8'h00, got);
      check("R8 status reads pending", int'(got), 1);
      txn(1'b0, 4'd15, 8'hfe, got);
      check("R9 bit0 zero write keeps pending", int'(irq_n), 0);
      txn(1'b0, 4'd15, 8'h01, got);
      check("R9 clear releases irq_n", int'(irq_n), 1);
      txn(1'b1, 4'd15, 8'h00, got);
      check("R8 status cleared", int'(got), 0);

      @(negedge clk);
      reg_addr = 4'd15; rd_not_wr = 1'b0; wr_data = 8'h01; start = 1'b1; event_in = 1'b1;
      @(negedge clk); start = 1'b0; #1;
      check("R9 event wins over clear", int'(irq_n), 0);
      repeat (4) @(negedge clk);
      event_in = 1'b0;
      txn(1'b0, 4'd15, 8'h01, got);
      check("R9 clear after event", int'(irq_n), 1);

      @(negedge clk);
      reg_addr = 4'd3; rd_not_wr = 1'b1; start = 1'b1;
      @(negedge clk); #1;
      check("R10 no done before latency", int'(done), 0);
      start = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); #1;
         check("R10 abandoned transaction stays low", int'(done), 0);
      end
      txn(1'b1, 4'd3, 8'h00, got);
      check("R10 next transaction normal", int'(got), int'(pat(3, 1)));

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule